// File: doc/BRIEF.md
# One-Shot OTG Event Timer

This block is a single programmable one-shot timer used to time on-the-go session events. Software programs one 32-bit control word: the top bit turns the timer on, and the low 27 bits give a delay counted in cycles of the device clock. When the delay has elapsed, the timer drops back to idle, clears its control word to zero and sends a one-cycle timeout pulse to the interrupt aggregator. The aggregator does any masking of that pulse.

Writing the control word with the top bit clear stops a running timer and leaves the written value readable. Writing it with the top bit set while the timer is already running starts the count again from the new value. The control word can be read back at any time. It returns the last written value until an expiry clears it.

Top module: `otg_evt_timer`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and the timeout output is low. A reset that occurs while the timer is running stops the timer without a pulse.
- R2: A write stores all 32 bits of the data. The read port returns that value on the cycle after the write edge. It keeps returning it until another write or an expiry.
- R3: A write with bit 31 set and count N in bits 26:0 arms the timer. The timeout output goes high directly after the clock edge that comes N+1 edges after the write edge.
- R4: A count of zero with bit 31 set expires on the first clock edge after the write edge.
- R5: The expiry edge clears the control word, so it reads 0x0000_0000 while the timeout pulse is high.
- R6: Each expiry produces a timeout pulse exactly one clock cycle long.
- R7: A write with bit 31 clear cancels a running timer. No pulse follows, and the written value stays readable.
- R8: A write with bit 31 set while the timer is running discards the old count. The pulse then follows the new count, as R3 describes.
- R9: Bits 30:27 are stored and read back but do not change the delay.
- R10: A write that lands on the same edge as an expiry takes priority. No pulse is produced, and the written value is kept and acted on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Device clock; also the tick that is counted |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Write data: bit 31 enable, bits 26:0 tick count |
| rd_data_o | output | 32 | Current control word |
| timeout_o | output | 1 | One-cycle pulse on expiry |

## Verification
A wrong count in the down-counter appears only as a timeout pulse at the wrong edge, which can be up to 2^27 cycles late. For that reason, the latency is measured exactly for counts from zero upward. The measurement is repeated after a restart, which catches any count carried over from the old value. A wrong armed flag shows as either a pulse after a cancel or a reset, or a missing pulse. A wrong control word shows at the read port on the next cycle, or as a nonzero read during the pulse. The edge where a write meets an expiry is driven deliberately, because an error in that priority shows as one spurious pulse and a lost write value.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;

    // Command derived from one control-word write
    typedef enum logic [1:0] {
        TCMD_NONE  = 2'd0,
        TCMD_START = 2'd1,
        TCMD_STOP  = 2'd2
    } tmr_cmd_e;

endpackage

// File: rtl/otg_tmr_decode.sv
module otg_tmr_decode
    import otg_tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 27
) (
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output tmr_cmd_e          cmd_o,
    output logic [CNT_W-1:0]  load_o
);
    localparam int ENA_POS = DATA_W - 1;

    always_comb begin
        load_o = wr_data_i[CNT_W-1:0];
        if (!wr_en_i) begin
            cmd_o = TCMD_NONE;
        end else if (wr_data_i[ENA_POS]) begin
            cmd_o = TCMD_START;
        end else begin
            cmd_o = TCMD_STOP;
        end
    end
endmodule

// File: rtl/otg_tmr_counter.sv
module otg_tmr_counter
    import otg_tmr_pkg::*;
#(
    parameter int CNT_W = 27
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  tmr_cmd_e         cmd_i,
    input  logic [CNT_W-1:0] load_i,
    output logic             expire_o
);
    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] remain;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        case (cmd_i)
            TCMD_START: begin
                st_d.armed  = 1'b1;
                st_d.remain = load_i;
            end
            TCMD_STOP: begin
                st_d.armed  = 1'b0;
                st_d.remain = '0;
            end
            default: begin
                if (st_q.armed) begin
                    if (st_q.remain == '0) begin
                        st_d.armed = 1'b0;
                        expire_o   = 1'b1;
                    end else begin
                        st_d.remain = st_q.remain - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3
    count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == TCMD_NONE && st_q.armed && st_q.remain != '0)
        |=> (st_q.armed && st_q.remain == $past(st_q.remain) - 1'b1));

    // R8
    reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == TCMD_START) |=> (st_q.armed && st_q.remain == $past(load_i)));

    // R7
    cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_i == TCMD_STOP) |=> !st_q.armed);
endmodule

// File: rtl/otg_evt_timer.sv
module otg_evt_timer
    import otg_tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 27
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              timeout_o
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              pulse;
    } top_state_t;

    top_state_t st_d, st_q;
    tmr_cmd_e          cmd;
    logic [CNT_W-1:0]  load_val;
    logic              expire;

    otg_tmr_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_decode (
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cmd_o     (cmd),
        .load_o    (load_val)
    );

    otg_tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .cmd_i    (cmd),
        .load_i   (load_val),
        .expire_o (expire)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = expire;
        if (wr_en_i) begin
            st_d.word = wr_data_i;
        end else if (expire) begin
            st_d.word = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.word;
    assign timeout_o = st_q.pulse;

    // R2
    wr_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o == $past(wr_data_i)));

    // R5
    clear_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |-> (rd_data_o == '0));

    // R6
    single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        timeout_o |=> !timeout_o);

    // R10
    write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> !timeout_o);
endmodule

// File: tb/test_otg_evt_timer.sv
module test_otg_evt_timer;
    localparam int NV    = 6;
    localparam int LIMIT = 2000;
    localparam logic [31:0] ENA = 32'h8000_0000;
    // stimulus counts and expected latency in edges (N+1, from R3/R4)
    localparam logic [31:0] VEC_CNT [NV] = '{32'd0, 32'd1, 32'd2, 32'd7, 32'd33, 32'd250};
    localparam int          VEC_LAT [NV] = '{1, 2, 3, 8, 34, 251};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        timeout;
    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    otg_evt_timer i_otg_evt_timer (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .timeout_o (timeout)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_pulse(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!timeout && cyc < LIMIT);
    endtask

    task automatic count_pulses(input int n, output int p);
        p = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (timeout) p++;
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int lat;
        int p;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset word", rd_data, 32'h0);
        check("R1 reset pulse", {31'h0, timeout}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R2, R3, R4, R5, R6
        for (int k = 0; k < NV; k++) begin
            do_write(ENA | VEC_CNT[k]);
            check("R2 readback while armed", rd_data, ENA | VEC_CNT[k]);
            wait_pulse(lat);
            if (VEC_CNT[k] == 0) check("R4 zero count latency", lat, VEC_LAT[k]);
            else                 check("R3 latency", lat, VEC_LAT[k]);
            check("R5 word cleared at expiry", rd_data, 32'h0);
            @(negedge clk);
            check("R6 pulse one cycle", {31'h0, timeout}, 32'h0);
            repeat (2) @(negedge clk);
        end

        // R7 cancel
        do_write(ENA | 32'd10);
        repeat (3) @(negedge clk);
        do_write(32'h0000_1234);
        count_pulses(30, p);
        check("R7 no pulse after cancel", p, 0);
        check("R7 cancel value kept", rd_data, 32'h0000_1234);

        // R8 restart
        do_write(ENA | 32'd10);
        repeat (5) @(negedge clk);
        do_write(ENA | 32'd20);
        wait_pulse(lat);
        check("R8 restart latency", lat, 21);
        repeat (2) @(negedge clk);

        // R9 bits 30:27 ignored for delay
        do_write(32'h8800_0003);
        check("R9 upper bits read back", rd_data, 32'h8800_0003);
        wait_pulse(lat);
        check("R9 latency unaffected", lat, 4);
        repeat (2) @(negedge clk);

        // R10 write on the expiry edge (N=3 expires on 4th edge after write)
        do_write(ENA | 32'd3);
        repeat (2) @(negedge clk);
        do_write(32'h0000_0055);
        check("R10 write value kept", rd_data, 32'h0000_0055);
        count_pulses(10, p);
        check("R10 no pulse on collision", p, 0);

        // R10 restart on expiry edge: new count honoured
        do_write(ENA | 32'd3);
        repeat (2) @(negedge clk);
        do_write(ENA | 32'd5);
        wait_pulse(lat);
        check("R10 restart on expiry edge", lat, 6);
        repeat (2) @(negedge clk);

        // R1 reset while armed
        do_write(ENA | 32'd40);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 word after mid-run reset", rd_data, 32'h0);
        rst_n = 1'b1;
        count_pulses(60, p);
        check("R1 no pulse after reset", p, 0);

        summary();
        $finish;
    end
endmodule